// File: doc/BRIEF.md
# Switch-Selected Wavetable Tone Generator

This block drives a 4-bit code into an external resistor-ladder converter. The code traces one sine period of 32 steps. Three switch lines pick one of three pitches. With none of them pressed, the generator rests at mid-scale.

A reloadable down-counter sets the sample rate. It runs for `CLK_HZ / (32 * f)` clocks per step, where `f` is the selected note frequency. On each expiry the block presents the current table step and advances a 5-bit index, which wraps. A note change does not disturb the running countdown. The new period takes effect at the next expiry, and the index continues where it was. The switch lines first pass a two-flop synchronizer. A plain priority rule then settles any overlap of presses.

The converter samples the code continuously, so the output is a plain level with no handshake. The block has no back-pressure: a code holds until the next expiry replaces it.

Top module: `tone_wavegen`

## Requirements
- R1: Each switch line passes two flip-flops before use. A change on `sw` affects the selected note only from the second rising clock edge after it is sampled, and a one-cycle pulse lasts one cycle in the selection.
- R2: `sw[0]` selects note 1 (default 523 Hz), `sw[1]` note 2 (440 Hz), `sw[2]` note 3 (392 Hz). When several lines are high, the lowest-numbered line wins. With all lines low the selection is stop.
- R3: While a note is selected and armed, successive output steps are exactly P clocks apart, with P = CLK_HZ / (32 * f) rounded down. At 50 MHz and 440 Hz this is 3551 clocks.
- R4: The steps follow the table 8,9,11,12,13,14,14,15,15,15,14,14,13,12,11,9,8,7,5,4,3,2,2,1,1,1,2,2,3,4,5,7, read at index 0 to 31. Index 31 is followed by index 0.
- R5: In stop, `dac_code` becomes 8 at the next edge. The countdown is held, and the table index does not advance.
- R6: On leaving stop, the counter loads P for the newly selected note on the first edge that sees the note. The first step appears P edges later.
- R7: A note change while armed lets the running countdown finish. The new P applies from that expiry on, and the table index is not reset.
- R8: After reset, `dac_code` is 8, the index is 0 and the selection is stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| sw | input | 3 | Note switches, active high, asynchronous to `clk` |
| dac_code | output | 4 | Code to the resistor-ladder converter |

## Verification
Two events can fall on the same edge. One is the counter expiry, which reloads and emits a step. The other is a selection change, either to a different note or to stop. The bench provokes this by sweeping the instant of each switch change across every phase of the running period, over a range of offsets. A reference model in the bench derives step times and codes from the note periods and the table. It compares `dac_code` against that model on every cycle, so a swallowed or doubled step, a wrong reload, or a reset index shows up at the exact cycle.

// File: rtl/tone_pkg.sv
package tone_pkg;

  localparam int NOTE_N    = 3;
  localparam int TABLE_LEN = 32;
  localparam int CODE_W    = 4;
  localparam int IDX_W     = $clog2(TABLE_LEN);
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1 << (CODE_W - 1));

  typedef enum logic [1:0] {
    MODE_STOP = 2'd0,
    MODE_N1   = 2'd1,
    MODE_N2   = 2'd2,
    MODE_N3   = 2'd3
  } mode_e;

  // One sine period, 32 steps, 4-bit amplitude.
  function automatic logic [CODE_W-1:0] sine_step(input logic [IDX_W-1:0] i);
    logic [CODE_W-1:0] v;
    case (i)
      5'd0:  v = 4'd8;  5'd1:  v = 4'd9;  5'd2:  v = 4'd11; 5'd3:  v = 4'd12;
      5'd4:  v = 4'd13; 5'd5:  v = 4'd14; 5'd6:  v = 4'd14; 5'd7:  v = 4'd15;
      5'd8:  v = 4'd15; 5'd9:  v = 4'd15; 5'd10: v = 4'd14; 5'd11: v = 4'd14;
      5'd12: v = 4'd13; 5'd13: v = 4'd12; 5'd14: v = 4'd11; 5'd15: v = 4'd9;
      5'd16: v = 4'd8;  5'd17: v = 4'd7;  5'd18: v = 4'd5;  5'd19: v = 4'd4;
      5'd20: v = 4'd3;  5'd21: v = 4'd2;  5'd22: v = 4'd2;  5'd23: v = 4'd1;
      5'd24: v = 4'd1;  5'd25: v = 4'd1;  5'd26: v = 4'd2;  5'd27: v = 4'd2;
      5'd28: v = 4'd3;  5'd29: v = 4'd4;  5'd30: v = 4'd5;  default: v = 4'd7;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/tone_sw_sync.sv
module tone_sw_sync
  import tone_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NOTE_N-1:0] sw_in,
  output mode_e             mode
);

  logic [NOTE_N-1:0] sw_meta;
  logic [NOTE_N-1:0] sw_s;
  logic [NOTE_N-1:0] grant;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_meta <= '0;
      sw_s    <= '0;
    end else begin
      sw_meta <= sw_in;
      sw_s    <= sw_meta;
    end
  end

  // Lowest-numbered pressed line wins.
  for (genvar g = 0; g < NOTE_N; g++) begin : g_grant
    if (g == 0) begin : g_first
      assign grant[g] = sw_s[g];
    end else begin : g_rest
      assign grant[g] = sw_s[g] & ~(|sw_s[g-1:0]);
    end
  end

  always_comb begin
    mode = MODE_STOP;
    for (int i = 0; i < NOTE_N; i++) begin
      if (grant[i]) mode = mode_e'(2'(i + 1));
    end
  end

  // R1: a selected note implies some line was high two edges earlier
  p_sync_delay_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_STOP) |-> $past(|sw_in, 2));

  // R2: note 2 only when line 1 was high and line 0 low two edges earlier
  p_prio_n2_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_N2) |-> $past(sw_in[1] && !sw_in[0], 2));

endmodule

// File: rtl/tone_tick_timer.sv
module tone_tick_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] period_m1,
  output logic             tick
);

  logic [CNT_W-1:0] count;
  logic             armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      armed <= 1'b0;
    end else if (!run) begin
      armed <= 1'b0;
    end else if (!armed) begin
      armed <= 1'b1;
      count <= period_m1;
    end else if (count == '0) begin
      count <= period_m1;
    end else begin
      count <= count - 1'b1;
    end
  end

  assign tick = run && armed && (count == '0);

  // R3: an armed, running, non-expired count steps down by one
  p_count_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && armed && count != '0) ##1 run |-> count == $past(count) - 1'b1);

  // R7: expiry reloads with the period presented at that edge
  p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> count == $past(period_m1));

  // R5: the countdown is frozen while stopped
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(count));

  // R6: arming loads the period at that edge
  p_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !armed) |=> (armed && count == $past(period_m1)));

endmodule

// File: rtl/tone_wave_out.sv
module tone_wave_out
  import tone_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop,
  input  logic              tick,
  output logic [CODE_W-1:0] dac_code
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TABLE_LEN - 1);

  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx      <= '0;
      dac_code <= MID_CODE;
    end else if (stop) begin
      dac_code <= MID_CODE;
    end else if (tick) begin
      dac_code <= sine_step(idx);
      idx      <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
    end
  end

  // R4: index wraps after the last entry
  p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !stop && idx == LAST_IDX) |=> idx == '0);

  // R5: stop forces mid-scale on the next edge
  p_stop_mid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> dac_code == MID_CODE);

  // R5: without a step the index is frozen
  p_idx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick || stop) |=> $stable(idx));

endmodule

// File: rtl/tone_wavegen.sv
module tone_wavegen
  import tone_pkg::*;
#(
  parameter int CLK_HZ   = 50_000_000,
  parameter int NOTE1_HZ = 523,
  parameter int NOTE2_HZ = 440,
  parameter int NOTE3_HZ = 392
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [tone_pkg::NOTE_N-1:0] sw,
  output logic [tone_pkg::CODE_W-1:0] dac_code
);

  localparam int P1   = CLK_HZ / (TABLE_LEN * NOTE1_HZ);
  localparam int P2   = CLK_HZ / (TABLE_LEN * NOTE2_HZ);
  localparam int P3   = CLK_HZ / (TABLE_LEN * NOTE3_HZ);
  localparam int PMAX = (P1 > P2) ? ((P1 > P3) ? P1 : P3) : ((P2 > P3) ? P2 : P3);
  localparam int CNT_W = $clog2(PMAX + 1);

  mode_e            mode;
  logic [CNT_W-1:0] period_m1;
  logic             run;
  logic             tick;

  tone_sw_sync u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .sw_in (sw),
    .mode  (mode)
  );

  always_comb begin
    case (mode)
      MODE_N1: period_m1 = CNT_W'(P1 - 1);
      MODE_N2: period_m1 = CNT_W'(P2 - 1);
      MODE_N3: period_m1 = CNT_W'(P3 - 1);
      default: period_m1 = '0;
    endcase
  end

  assign run = (mode != MODE_STOP);

  tone_tick_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .period_m1 (period_m1),
    .tick      (tick)
  );

  tone_wave_out u_wave (
    .clk      (clk),
    .rst_n    (rst_n),
    .stop     (!run),
    .tick     (tick),
    .dac_code (dac_code)
  );

  initial begin
    // R3: every note needs at least one clock per step
    a_period_r3: assert (P1 >= 1 && P2 >= 1 && P3 >= 1);
  end

endmodule

// File: tb/tone_wavegen_tb_top.sv
module tone_wavegen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int T_CLK_HZ = 3200;
  localparam int T_F1 = 25;   // P = 4
  localparam int T_F2 = 20;   // P = 5
  localparam int T_F3 = 10;   // P = 10

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sw = 3'b000;
  logic [3:0] dac_code;

  int n_checks = 0;
  int n_fail   = 0;
  string cur_tag = "R8";
  bit checking = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tone_wavegen #(
    .CLK_HZ(T_CLK_HZ), .NOTE1_HZ(T_F1), .NOTE2_HZ(T_F2), .NOTE3_HZ(T_F3)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .sw(sw), .dac_code(dac_code)
  );

  int tab [32] = '{8,9,11,12,13,14,14,15,15,15,14,14,13,12,11,9,
                   8,7,5,4,3,2,2,1,1,1,2,2,3,4,5,7};

  function automatic int note_of(logic [2:0] s);
    if (s[0]) return 1;
    if (s[1]) return 2;
    if (s[2]) return 3;
    return 0;
  endfunction

  function automatic int period_of(int n);
    case (n)
      1: return T_CLK_HZ / (32 * T_F1);
      2: return T_CLK_HZ / (32 * T_F2);
      default: return T_CLK_HZ / (32 * T_F3);
    endcase
  endfunction

  // Reference model: two-edge delay, then per-step wait counting.
  logic [2:0] m_s1, m_s2;
  bit m_armed;
  int m_wait, m_idx, m_out;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_armed <= 0;
      m_wait <= 0; m_idx <= 0; m_out <= 8;
    end else begin
      int n;
      m_s1 <= sw;
      m_s2 <= m_s1;
      n = note_of(m_s2);
      if (n == 0) begin
        m_out <= 8;
        m_armed <= 0;
      end else if (!m_armed) begin
        m_armed <= 1;
        m_wait <= period_of(n);
      end else if (m_wait == 1) begin
        m_out <= tab[m_idx];
        m_idx <= (m_idx + 1) % 32;
        m_wait <= period_of(n);
      end else begin
        m_wait <= m_wait - 1;
      end
    end
  end

  task automatic check_out(string tag, int exp);
    n_checks++;
    if (int'(dac_code) != exp) begin
      n_fail++;
      $display("FAIL %s: dac_code=%0d expected %0d at %0t", tag, dac_code, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (checking && rst_n) check_out(cur_tag, m_out);
  end

  task automatic hold(logic [2:0] s, int cycles);
    sw = s;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: output at mid-scale while and after reset
    check_out("R8", 8);
    rst_n = 1'b1;
    @(negedge clk);
    check_out("R8", 8);
    checking = 1'b1;
    cur_tag = "R8";
    hold(3'b000, 6);

    // R4: a long run on note 1 covers several table wraps
    cur_tag = "R4";
    hold(3'b001, 300);
    // R3: steady runs on each pitch
    cur_tag = "R3";
    hold(3'b000, 5);
    hold(3'b010, 200);
    hold(3'b000, 5);
    hold(3'b100, 400);
    hold(3'b000, 5);

    // R2: every switch combination, including overlaps
    cur_tag = "R2";
    for (int c = 0; c < 8; c++) hold(3'(c), 60);
    hold(3'b111, 40);
    hold(3'b110, 40);
    hold(3'b101, 40);

    // R7 and R5: note change or stop landing on every phase of the period
    for (int off = 0; off < 12; off++) begin
      cur_tag = "R7";
      hold(3'b001, 40 + off);
      hold(3'b100, 30);
      hold(3'b010, 20 + off);
      cur_tag = "R5";
      hold(3'b000, 7);
    end

    // R6: arming from stop at varied gaps
    cur_tag = "R6";
    for (int g = 1; g < 8; g++) begin
      hold(3'b000, g);
      hold(3'b010, 12 + g);
    end
    hold(3'b000, 5);

    // R1: single-cycle and two-cycle pulses through the synchronizer
    cur_tag = "R1";
    for (int w = 1; w < 6; w++) begin
      hold(3'b001, w);
      hold(3'b000, 8);
    end
    hold(3'b000, 10);

    checking = 1'b0;
    done = 1'b1;
    summary();
    $finish;
  end

endmodule